// File: doc/BRIEF.md
# I2C Register Target with Coherent Temperature Snapshot

This block is an I2C target that exposes four byte-wide registers to a bus controller. Two of them hold a frequency-tuning word that drives the block's tuning outputs. The other two present a 12-bit temperature code and cannot be written. An on-chip measurement path delivers a live temperature word with a valid strobe, and the block keeps the most recent value in a live register.

The bus-visible temperature copy is not refreshed on every measurement. It is refreshed only when a controller addresses the target for writing and then sends a word-address byte. Reads never refresh it. A controller therefore sets the word pointer to the temperature's high byte and then reads both bytes in one transfer, and gets a coherent pair even if new measurements arrive during the read.

Both bus lines are sampled with the system clock through a synchronizer and a glitch filter. START and STOP are recognised from the filtered lines. The target drives SDA only through an active-high pull-down enable and never drives SCL.

Top module: `i2c_temp_regs`

## Requirements
- R1: After reset the tuning outputs are all zero. The live temperature and the bus-visible temperature both hold the +25 °C code 12'h190, so reading registers 2 and 3 returns 8'h19 and 8'h00.
- R2: `conv_req_o` is high while reset is asserted and during the first clock after it is released, and it stays low from then on.
- R3: The bus-visible temperature takes the live value at exactly one point: after an acknowledged write address has been followed by a complete word-address byte. Only the low two bits of the word-address byte select the register.
- R4: Read transfers never change the bus-visible temperature. A multi-byte read of registers 2 and 3 returns one consistent code even if the live value changes during the read.
- R5: The address byte carries the 7-bit target address (default 7'h50) in bits 7:1 and R/W in bit 0, where 0 means write. Every byte is sent MSB first. The receiver pulls SDA low on the ninth clock to acknowledge. The target changes SDA only while SCL is low.
- R6: An address that does not match gets no acknowledge. The target then ignores every clock until the next START, and neither the registers nor the word pointer change.
- R7: The word pointer advances by one after every data byte, whether read or written, and wraps from 3 to 0.
- R8: Data bytes written to registers 2 and 3 are acknowledged and discarded. The low nibble of register 3 always reads as 0. The register holds temperature bits 11:4 in register 2 and bits 3:0 in bits 7:4 of register 3.
- R9: Bit 7 of register 0 drives `tune_dis_o` and bit 6 drives `tune_sign_o`. Register 0 bits 5:0 concatenated with register 1 form the 14-bit `tune_mag_o`, with register 0 bits 5:0 as the upper bits.
- R10: When the controller does not acknowledge a read byte, the target releases SDA and stays off the bus until the next START.
- R11: A pulse on either line that is shorter than FILT_LEN clocks (default 3) is ignored. A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| temp_i | input | 12 | Live temperature code, two's complement, 1/16 °C per LSB |
| temp_valid_i | input | 1 | Strobe that loads `temp_i` into the live register |
| conv_req_o | output | 1 | Conversion request issued after reset |
| tune_dis_o | output | 1 | Compensation-disable flag |
| tune_sign_o | output | 1 | Sign of the tuning word |
| tune_mag_o | output | 14 | Magnitude of the tuning word |

## Verification
Four properties are checked on every cycle:
- The pull-down enable changes only while SCL is low.
- The tuning outputs move only in the cycle after an internal register write.
- The bus-visible temperature moves only in the cycle after a snapshot strobe.
- The conversion request never rises again once it has fallen.

Other behaviour needs whole transfers and only the bench scenarios can show it:
- read coherence while live values change mid-read
- pointer wrap
- silence after a mismatched address or a controller NACK
- rejection of short pulses on both lines

Random write, addressed-read and current-address-read transfers are checked against a bench model of the four registers.

// File: rtl/i2c_temp_pkg.sv
package i2c_temp_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned PTR_W    = $clog2(NUM_REGS);
  localparam int unsigned TEMP_W   = 12;
  localparam logic [TEMP_W-1:0] TEMP_RST = 12'h190;  // +25 C at 1/16 C per LSB

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_ACK_OUT,
    ST_RX,
    ST_TX,
    ST_ACK_IN
  } tgt_state_e;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (sync_q[SYNC_STAGES-1] == level_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        level_q <= ~level_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_temp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             snap_o,
  output logic             sda_oe_o
);
  tgt_state_e       state_q;
  logic [3:0]       bit_cnt_q;
  logic [REG_W-1:0] shreg_q;
  logic [PTR_W-1:0] ptr_q;
  logic             rw_q, waddr_pend_q, nack_q, sda_oe_q;
  logic             wr_en_q, snap_q;
  logic [PTR_W-1:0] wr_addr_q;
  logic [REG_W-1:0] wr_data_q;

  wire byte_done = (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      shreg_q      <= '0;
      ptr_q        <= '0;
      rw_q         <= 1'b0;
      waddr_pend_q <= 1'b0;
      nack_q       <= 1'b0;
      sda_oe_q     <= 1'b0;
      wr_en_q      <= 1'b0;
      snap_q       <= 1'b0;
      wr_addr_q    <= '0;
      wr_data_q    <= '0;
    end else begin
      wr_en_q <= 1'b0;
      snap_q  <= 1'b0;
      if (start_i) begin
        state_q   <= ST_DEVADR;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEVADR, ST_RX: begin
            if (scl_rise_i && !byte_done) begin
              shreg_q   <= {shreg_q[REG_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && byte_done) begin
              if (state_q == ST_DEVADR) begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  rw_q         <= shreg_q[0];
                  waddr_pend_q <= ~shreg_q[0];
                  sda_oe_q     <= 1'b1;
                  state_q      <= ST_ACK_OUT;
                end else begin
                  state_q <= ST_IDLE;  // not addressed: wait for next START
                end
              end else begin
                if (waddr_pend_q) begin
                  ptr_q        <= shreg_q[PTR_W-1:0];
                  snap_q       <= 1'b1;
                  waddr_pend_q <= 1'b0;
                end else begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= shreg_q;
                  ptr_q     <= ptr_q + 1'b1;
                end
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK_OUT;
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                shreg_q  <= rd_data_i;
                sda_oe_q <= ~rd_data_i[REG_W-1];
                state_q  <= ST_TX;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (byte_done) begin
                sda_oe_q <= 1'b0;
                ptr_q    <= ptr_q + 1'b1;
                state_q  <= ST_ACK_IN;
              end else begin
                shreg_q  <= {shreg_q[REG_W-2:0], 1'b0};
                sda_oe_q <= ~shreg_q[REG_W-2];
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                shreg_q   <= rd_data_i;
                sda_oe_q  <= ~rd_data_i[REG_W-1];
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign snap_o    = snap_q;
  assign sda_oe_o  = sda_oe_q;
endmodule

// File: rtl/i2c_temp_regs.sv
module i2c_temp_regs
  import i2c_temp_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_valid_i,
  output logic              conv_req_o,
  output logic              tune_dis_o,
  output logic              tune_sign_o,
  output logic [13:0]       tune_mag_o
);
  localparam int unsigned NPINS = 2;

  logic [NPINS-1:0] pin_raw, pin_flt;
  assign pin_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    i2c_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_raw[g]),
      .level_o(pin_flt[g])
    );
  end

  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (pin_flt[1]),
    .sda_i     (pin_flt[0]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  logic [PTR_W-1:0] rd_addr, reg_wr_addr;
  logic [REG_W-1:0] rd_data, reg_wr_data;
  logic             reg_wr_en, snap_en;

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (pin_flt[0]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (reg_wr_en),
    .wr_addr_o (reg_wr_addr),
    .wr_data_o (reg_wr_data),
    .snap_o    (snap_en),
    .sda_oe_o  (sda_oe_o)
  );

  logic [REG_W-1:0]  tune_hi_q, tune_lo_q;
  logic [TEMP_W-1:0] live_temp_q, user_temp_q;
  logic              conv_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_hi_q   <= '0;
      tune_lo_q   <= '0;
      live_temp_q <= TEMP_RST;
      user_temp_q <= TEMP_RST;
      conv_req_q  <= 1'b1;
    end else begin
      conv_req_q <= 1'b0;
      if (temp_valid_i) live_temp_q <= temp_i;
      if (snap_en)      user_temp_q <= live_temp_q;
      if (reg_wr_en) begin
        if (reg_wr_addr == PTR_W'(0)) tune_hi_q <= reg_wr_data;
        if (reg_wr_addr == PTR_W'(1)) tune_lo_q <= reg_wr_data;
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      PTR_W'(0): rd_data = tune_hi_q;
      PTR_W'(1): rd_data = tune_lo_q;
      PTR_W'(2): rd_data = user_temp_q[11:4];
      default:   rd_data = {user_temp_q[3:0], 4'h0};
    endcase
  end

  assign conv_req_o  = conv_req_q;
  assign tune_dis_o  = tune_hi_q[7];
  assign tune_sign_o = tune_hi_q[6];
  assign tune_mag_o  = {tune_hi_q[5:0], tune_lo_q};
endmodule

// File: rtl/i2c_temp_regs_chk.sv
module i2c_temp_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic        conv_req_o,
  input logic [15:0] tune_vec,
  input logic        wr_en,
  input logic        snap_en,
  input logic [11:0] user_temp
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);  // R5

  AST_TUNE_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tune_vec) |-> $past(wr_en));  // R9

  AST_TEMP_ONLY_ON_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(user_temp) |-> $past(snap_en));  // R3

  AST_CONV_REQ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(conv_req_o));  // R2
endmodule

bind i2c_temp_regs i2c_temp_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .conv_req_o(conv_req_o),
  .tune_vec  ({tune_dis_o, tune_sign_o, tune_mag_o}),
  .wr_en     (reg_wr_en),
  .snap_en   (snap_en),
  .user_temp (user_temp_q)
);

// File: tb/i2c_temp_regs_bench.sv
module i2c_temp_regs_bench;
  localparam int Q = 12;
  localparam logic [6:0] ADDR = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic [11:0] temp = '0;
  logic temp_valid = 1'b0;
  logic sda_oe, conv_req, tune_dis, tune_sign;
  logic [13:0] tune_mag;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_temp_regs u_i2c_temp_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .temp_i(temp), .temp_valid_i(temp_valid),
    .conv_req_o(conv_req), .tune_dis_o(tune_dis), .tune_sign_o(tune_sign),
    .tune_mag_o(tune_mag)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_reg0 = 0, m_reg1 = 0;
  logic [11:0] m_live = 12'h190, m_user = 12'h190;
  logic [1:0] m_ptr = 0;

  function automatic logic [7:0] exp_byte(input logic [1:0] p);
    case (p)
      2'd0: return m_reg0;
      2'd1: return m_reg1;
      2'd2: return m_user[11:4];
      default: return {m_user[3:0], 4'h0};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input logic b, input bit glitch);
    m_sda_low = !b;
    clks(Q / 2);
    if (glitch) begin m_scl = 1'b1; clks(1); m_scl = 1'b0; end
    clks(Q / 2 - (glitch ? 1 : 0));
    m_scl = 1'b1;
    clks(Q);
    if (glitch) begin m_sda_low = !m_sda_low; clks(1); m_sda_low = !m_sda_low; end
    clks(Q - (glitch ? 1 : 0));
    m_scl = 1'b0;
    clks(Q);
  endtask

  task automatic rbit(output logic b);
    m_sda_low = 1'b0;
    clks(Q);
    m_scl = 1'b1;
    clks(Q);
    b = sda_line;
    clks(Q);
    m_scl = 1'b0;
    clks(Q);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; clks(Q);
    m_scl = 1'b1; clks(Q);
    m_sda_low = 1'b1; clks(Q);
    m_scl = 1'b0; clks(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; clks(Q);
    m_scl = 1'b1; clks(Q);
    m_sda_low = 1'b0; clks(Q);
  endtask

  task automatic send(input logic [7:0] b, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(b[i], glitch);
    rbit(s);
    ack = !s;
  endtask

  task automatic recv(input logic last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) rbit(b[i]);
    wbit(last, 1'b0);
  endtask

  task automatic set_live(input logic [11:0] v);
    temp = v; temp_valid = 1'b1; clks(1); temp_valid = 1'b0; clks(1);
    m_live = v;
  endtask

  task automatic open_write(input logic [1:0] wa);
    logic ack;
    bus_start();
    send({ADDR, 1'b0}, 1'b0, ack);
    chk("R5 write address ack", ack, 1);
    send({6'h2A, wa}, 1'b0, ack);  // upper bits ignored
    chk("R3 word address ack", ack, 1);
    m_ptr = wa; m_user = m_live;
  endtask

  task automatic put(input logic [7:0] d, input bit glitch);
    logic ack;
    send(d, glitch, ack);
    chk("R8 data ack", ack, 1);
    if (m_ptr == 2'd0) m_reg0 = d;
    if (m_ptr == 2'd1) m_reg1 = d;
    m_ptr = m_ptr + 1'b1;
  endtask

  task automatic open_read(input bit repeated);
    logic ack;
    bus_start();
    send({ADDR, 1'b1}, 1'b0, ack);
    chk(repeated ? "R11 repeated start read ack" : "R5 read address ack", ack, 1);
  endtask

  task automatic get(input logic last, input string tag);
    logic [7:0] b;
    logic [7:0] e;
    e = exp_byte(m_ptr);
    recv(last, b);
    chk(tag, b, e);
    m_ptr = m_ptr + 1'b1;
  endtask

  task automatic chk_tune(input string tag);
    chk(tag, {tune_dis, tune_sign, tune_mag}, {m_reg0, m_reg1});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'h5EED_0042));
    clks(4);
    chk("R2 conv_req during reset", conv_req, 1);
    chk("R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    clks(3);
    chk("R2 conv_req drops after reset", conv_req, 0);
    chk_tune("R1 tuning outputs reset");

    // R4: reads never take a snapshot; current-address read from pointer 0
    set_live(12'hABC);
    open_read(0);
    get(0, "R1 read reg0"); get(0, "R1 read reg1");
    get(0, "R4 reg2 still reset value"); get(1, "R4 reg3 still reset value");
    bus_stop();

    // R3: write address plus word address takes the snapshot
    open_write(2'd2); bus_stop();
    open_read(0);
    get(0, "R3 snapshot high byte"); get(1, "R3 snapshot low nibble");
    bus_stop();

    // R9: tuning field mapping
    open_write(2'd0); put(8'hC5, 0); put(8'h3A, 0); bus_stop();
    chk("R9 dis flag", tune_dis, 1);
    chk("R9 sign flag", tune_sign, 1);
    chk("R9 magnitude", tune_mag, 14'h053A);

    // R8 and R7: writes to 2 and 3 discarded, wrap from 3 to 0
    set_live(12'h7F1);
    open_write(2'd2); put(8'h55, 0); put(8'h66, 0); put(8'h12, 0); bus_stop();
    chk_tune("R7 wrap write reached reg0");
    open_write(2'd2);
    bus_start();
    open_read(1);
    get(0, "R8 reg2 unchanged by write"); get(0, "R8 reg3 low nibble zero");
    get(0, "R7 wrap read reg0"); get(1, "R7 read reg1");
    bus_stop();

    // R6: mismatched address ignored until next START
    bus_start();
    send({ADDR ^ 7'h01, 1'b0}, 0, ack);
    chk("R6 mismatch not acked", ack, 0);
    send(8'h00, 0, ack);
    chk("R6 later byte not acked", ack, 0);
    send(8'hFF, 0, ack);
    bus_stop();
    chk_tune("R6 tuning unchanged");
    open_read(0); get(1, "R6 pointer unchanged"); bus_stop();

    // R10: NACK ends the read
    open_read(0); get(1, "R10 byte before nack");
    clks(2);
    chk("R10 sda released after nack", sda_oe, 0);
    for (int i = 7; i >= 0; i--) rbit(b[i]);
    chk("R10 no drive after nack", b, 8'hFF);
    bus_stop();

    // R11: short pulses on SCL and SDA ignored
    open_write(2'd1); put(8'hA7, 1); put(8'h3C, 1); bus_stop();
    chk_tune("R11 glitched write decoded");

    // R4: live value changes in the middle of a coherent read
    set_live(12'h123);
    open_write(2'd2); bus_start(); open_read(1);
    get(0, "R4 coherent high byte");
    set_live(12'hFED);
    get(1, "R4 coherent low byte");
    bus_stop();

    // random mix
    for (int t = 0; t < 24; t++) begin
      int op, n;
      op = $urandom % 3;
      n  = 1 + ($urandom % 4);
      if ($urandom % 2) set_live(12'($urandom));
      if (op == 0) begin
        open_write(2'($urandom));
        for (int k = 0; k < n; k++) put(8'($urandom), 0);
        bus_stop();
        chk_tune("R9 random write tuning");
      end else begin
        if (op == 1) begin open_write(2'($urandom)); bus_start(); open_read(1); end
        else open_read(0);
        for (int k = 0; k < n; k++) begin
          if (k == 1) set_live(12'($urandom));
          get(k == n - 1, "R7 random read");
        end
        bus_stop();
      end
    end

    summary();
    $finish;
  end
endmodule